// File: doc/BRIEF.md
# Burst Address Counter with Replay

This block produces the address for one port of a synchronous memory. At each rising clock edge it chooses one of four actions: take a new address from the external bus, step the current address up by one, return to the address most recently taken from the bus, or keep the current address. The current address goes straight to the memory array from a register.

A second register holds a copy of the address taken by the last strobe. A burst can then be started again from its first word with the replay control, and the address does not have to be driven onto the bus again. The three action controls are active low. An active-high select input gates all three.

The register is `ADDR_W` bits wide. A smaller memory can use the same port width with fewer bits that count, set by `ACTIVE_W`. The bits above `ACTIVE_W` then stay at zero, and the count wraps inside the bits that count.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset the address output is zero, and so is the replay copy. A replay issued as the first command therefore gives address zero.
- R2: With select high, replay_n high and strobe_n low, the address output equals addr_in after the next rising edge. addr_in is masked to its low ACTIVE_W bits.
- R3: With select high, replay_n and strobe_n high and step_n low, the address output rises by one at the next rising edge.
- R4: With select high and replay_n low, the address output equals the replay copy after the next rising edge.
- R5: When several controls are low together, replay wins over strobe and strobe wins over step. A strobe together with a step gives the loaded address, not the loaded address plus one.
- R6: With select high and all three controls high, the address output does not change.
- R7: The replay copy changes only on a strobe load that takes effect. A step, a replay, or a strobe that loses to a replay leaves it unchanged.
- R8: Stepping from the address whose low ACTIVE_W bits are all ones gives zero.
- R9: With select low, every control is ignored. Neither the address output nor the replay copy changes.
- R10: Bits of the address output at positions ACTIVE_W and above are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Port select. When low, all controls are ignored |
| strobe_n | input | 1 | Load addr_in, active low |
| step_n | input | 1 | Advance by one, active low |
| replay_n | input | 1 | Return to the last loaded address, active low |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current address to the memory array |

## Verification
The bench builds two copies of the block from the same controls. The first uses the default 18-bit width with every bit counting, so a full-span wrap from 0x3FFFF to zero is reached with a single load and step. The second uses a 5-bit register with only 4 bits counting. It brings within reach the masking of an out-of-range load and the wrap inside the narrower span, with the unused top bit held at zero.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Action chosen for one clock edge, after select gating and priority
    typedef enum logic [1:0] {
        CMD_HOLD   = 2'd0,
        CMD_STEP   = 2'd1,
        CMD_LOAD   = 2'd2,
        CMD_REPLAY = 2'd3
    } burst_cmd_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_addr_pkg::*;
(
    input  logic       sel,
    input  logic       strobe_n,
    input  logic       step_n,
    input  logic       replay_n,
    output burst_cmd_e cmd
);

    // Patterns do not overlap. Replay over strobe over step; select gates all.
    always_comb begin
        unique casez ({sel, replay_n, strobe_n, step_n})
            4'b0???: cmd = CMD_HOLD;
            4'b10??: cmd = CMD_REPLAY;
            4'b110?: cmd = CMD_LOAD;
            4'b1110: cmd = CMD_STEP;
            4'b1111: cmd = CMD_HOLD;
            default: cmd = CMD_HOLD;
        endcase
    end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int ACTIVE_W = ADDR_W
) (
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] shadow,
    input  logic [ADDR_W-1:0] ext,
    output logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] shadow_nxt
);

    localparam int UNUSED_W = ADDR_W - ACTIVE_W;
    localparam logic [ADDR_W-1:0] LIVE_MASK = {ADDR_W{1'b1}} >> UNUSED_W;
    localparam logic [ACTIVE_W-1:0] ONE_A = 1;

    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] ext_live;

    assign ext_live = ext & LIVE_MASK;

    // The incrementer spans only the bits that count
    generate
        if (UNUSED_W == 0) begin : g_full_inc
            assign inc = cur + ONE_A;
        end else begin : g_part_inc
            logic [ACTIVE_W-1:0] low_inc;
            assign low_inc = cur[ACTIVE_W-1:0] + ONE_A;
            assign inc     = {{UNUSED_W{1'b0}}, low_inc};
        end
    endgenerate

    always_comb begin
        nxt        = cur;
        shadow_nxt = shadow;
        unique case (cmd)
            CMD_HOLD:   nxt = cur;
            CMD_STEP:   nxt = inc;
            CMD_LOAD: begin
                nxt        = ext_live;
                shadow_nxt = ext_live;
            end
            CMD_REPLAY: nxt = shadow;
            default:    nxt = cur;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int ACTIVE_W = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              replay_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    burst_cmd_e        cmd;
    logic [ADDR_W-1:0] cnt_q;
    logic [ADDR_W-1:0] shadow_q;
    logic [ADDR_W-1:0] cnt_d;
    logic [ADDR_W-1:0] shadow_d;

    burst_cmd_decode u_decode (
        .sel      (sel),
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .replay_n (replay_n),
        .cmd      (cmd)
    );

    burst_next_addr #(
        .ADDR_W   (ADDR_W),
        .ACTIVE_W (ACTIVE_W)
    ) u_next (
        .cmd        (cmd),
        .cur        (cnt_q),
        .shadow     (shadow_q),
        .ext        (addr_in),
        .nxt        (cnt_d),
        .shadow_nxt (shadow_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shadow_q <= '0;
        end else begin
            cnt_q    <= cnt_d;
            shadow_q <= shadow_d;
        end
    end

    // Outputs
    always_comb begin
        addr_out = cnt_q;
    end

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W   = 18,
    parameter int ACTIVE_W = ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              strobe_n,
    input logic              step_n,
    input logic              replay_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [ADDR_W-1:0] shadow_q
);

    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} >> (ADDR_W - ACTIVE_W);
    localparam logic [ADDR_W-1:0] ONE  = 1;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && replay_n && !strobe_n) |=> addr_out == ($past(addr_in) & MASK));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && replay_n && strobe_n && !step_n)
            |=> addr_out == (($past(addr_out) + ONE) & MASK));

    assert_replay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !replay_n) |=> addr_out == $past(shadow_q));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && replay_n && strobe_n && step_n) |=> $stable(addr_out));

    assert_shadow_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && replay_n && !strobe_n) |=> $stable(shadow_q));

    assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(addr_out));

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_out & ~MASK) == '0);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W   (ADDR_W),
    .ACTIVE_W (ACTIVE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .replay_n (replay_n),
    .addr_in  (addr_in),
    .addr_out (addr_out),
    .shadow_q (shadow_q)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int W  = 18;
    localparam int HW = 5;
    localparam int HA = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b1;
    logic          strobe_n = 1'b1;
    logic          step_n = 1'b1;
    logic          replay_n = 1'b1;
    logic [W-1:0]  addr_in = '0;
    logic [W-1:0]  addr_out;
    logic [HW-1:0] addr_out_h;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .strobe_n(strobe_n),
        .step_n(step_n), .replay_n(replay_n), .addr_in(addr_in),
        .addr_out(addr_out)
    );

    burst_addr_gen #(.ADDR_W(HW), .ACTIVE_W(HA)) u_dut_half (
        .clk(clk), .rst_n(rst_n), .sel(sel), .strobe_n(strobe_n),
        .step_n(step_n), .replay_n(replay_n), .addr_in(addr_in[HW-1:0]),
        .addr_out(addr_out_h)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one command for one edge, then sample shortly after it
    task automatic cyc(input logic s, input logic rp, input logic sb,
                       input logic st, input logic [W-1:0] a);
        @(negedge clk);
        sel = s; replay_n = rp; strobe_n = sb; step_n = st; addr_in = a;
        @(posedge clk);
        #2;
        sel = 1'b1; replay_n = 1'b1; strobe_n = 1'b1; step_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 reset addr", addr_out, '0);
        check("R1 reset addr narrow", W'(addr_out_h), '0);
        cyc(1, 0, 1, 1, 18'h155);
        check("R1 replay after reset", addr_out, '0);
    endtask

    task automatic t_load_step();
        cyc(1, 1, 0, 1, 18'h2A5C3);
        check("R2 load", addr_out, 18'h2A5C3);
        for (int i = 1; i <= 3; i++) begin
            cyc(1, 1, 1, 0, '0);
            check("R3 step", addr_out, 18'h2A5C3 + 18'(i));
        end
        cyc(1, 1, 1, 1, 18'h11111);
        cyc(1, 1, 1, 1, 18'h22222);
        check("R6 hold", addr_out, 18'h2A5C6);
    endtask

    task automatic t_replay();
        cyc(1, 0, 1, 1, '0);
        check("R4 replay", addr_out, 18'h2A5C3);
        cyc(1, 1, 1, 0, '0);
        cyc(1, 0, 1, 1, '0);
        check("R7 shadow kept after step and replay", addr_out, 18'h2A5C3);
    endtask

    task automatic t_priority();
        cyc(1, 1, 0, 1, 18'h00040);
        cyc(1, 1, 1, 0, '0);
        cyc(1, 0, 0, 0, 18'h3F00F);
        check("R5 replay beats strobe", addr_out, 18'h00040);
        cyc(1, 1, 1, 0, '0);
        cyc(1, 0, 1, 1, '0);
        check("R7 losing strobe leaves shadow", addr_out, 18'h00040);
        cyc(1, 1, 0, 0, 18'h00100);
        check("R5 strobe beats step", addr_out, 18'h00100);
    endtask

    task automatic t_wrap();
        cyc(1, 1, 0, 1, 18'h3FFFF);
        check("R2 load all ones", addr_out, 18'h3FFFF);
        cyc(1, 1, 1, 0, '0);
        check("R8 wrap", addr_out, '0);
    endtask

    task automatic t_deselect();
        cyc(1, 1, 0, 1, 18'h01234);
        cyc(0, 1, 0, 1, 18'h05555);
        check("R9 strobe ignored", addr_out, 18'h01234);
        cyc(0, 1, 1, 0, '0);
        check("R9 step ignored", addr_out, 18'h01234);
        cyc(1, 1, 1, 0, '0);
        cyc(0, 0, 1, 1, '0);
        check("R9 replay ignored", addr_out, 18'h01235);
        cyc(1, 0, 1, 1, '0);
        check("R9 shadow unchanged", addr_out, 18'h01234);
    endtask

    task automatic t_narrow();
        cyc(1, 1, 0, 1, 18'h0001E);
        check("R10 narrow load masked", W'(addr_out_h), 18'h0000E);
        cyc(1, 1, 0, 1, 18'h0000F);
        cyc(1, 1, 1, 0, '0);
        check("R8 narrow wrap", W'(addr_out_h), '0);
        cyc(1, 1, 1, 0, '0);
        check("R10 narrow step", W'(addr_out_h), 18'h00001);
    endtask

    initial begin
        #35 rst_n = 1'b1;
        #1;
        t_reset();
        t_load_step();
        t_replay();
        t_priority();
        t_wrap();
        t_deselect();
        t_narrow();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule